// File: doc/BRIEF.md
# DMA Versus CPU Bus Arbiter

This block settles, on every clock, which master owns the memory bus: the CPU or one of the DMA channels. A grant is a combinational decision made from the current requests and a small amount of held state, so the master that is granted uses the bus in that same cycle. By default a DMA channel that is asking for the bus takes it ahead of the CPU. Three conditions keep DMA off the bus and give it to the CPU: an NMI, a locked CPU sequence, and the second half of a CPU word access to an odd address.

Each channel takes its own control word. The used fields are: bit 9, stop at terminal count; bit 8, interrupt on the final transfer; bit 5, high priority; bit 4, the timer request drives the channel; bit 3, the request pin becomes an interrupt input; bit 0, word transfer. Each channel also keeps a 16-bit transfer count. Software loads the count through a load strobe, and every grant to the channel decrements it. The DMA datapath and address generation sit outside this block.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and right after reset, no grant is asserted and no terminal-count interrupt is pending. The transfer counts and the round-robin pointer start at zero.
- R2: A channel that is asking for the bus and is not blocked is granted ahead of the CPU. Among requesting channels, one with control bit 5 set wins over one with bit 5 clear.
- R3: While `cpu_lock_i` is high, no channel is granted.
- R4: While `nmi_i` is high, no channel is granted.
- R5: A granted CPU word access with `cpu_addr0_i` high takes two cycles. In the cycle after the first half, the CPU is granted and no channel is, whatever the requests are.
- R6: With control bit 9 set and a count of zero, the channel's requests are ignored. With bit 9 clear, the channel keeps running and the count wraps from 0 to 0xFFFF.
- R7: With control bit 8 set, a grant that takes the count from 1 to 0 raises a one-cycle pulse on `tc_irq_o` in the following cycle.
- R8: With control bit 4 set, `tmr2_req_i` is the channel's request source in place of its pin. While a channel is granted, `dma_word_o` equals its control bit 0; with no channel granted it is 0.
- R9: With control bit 4 clear and bit 3 set, the channel's pin does not request the bus. In that case `pin_irq_o` follows the pin (bit 3 and pin).
- R10: When channels of equal priority request together, grants rotate: after channel c is granted, the search starts at channel c+1.
- R11: `cnt_load_i` loads `cnt_data_i` into the count at the clock edge. A load takes precedence over a decrement in the same cycle, and that cycle raises no interrupt.
- R12: The CPU is granted whenever it requests and no channel is granted. At most one grant is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU requests a bus cycle |
| cpu_word_i | input | 1 | CPU cycle is a word access |
| cpu_addr0_i | input | 1 | Address bit 0 of the CPU access |
| cpu_lock_i | input | 1 | CPU is holding a locked sequence |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| dma_pin_i | input | NCH | Per-channel request pins |
| tmr2_req_i | input | 1 | Timer request, shared by all channels |
| chan_ctrl_i | input | NCH*16 | Control words, channel c at bits [16c+15:16c] |
| cnt_load_i | input | NCH | Per-channel count load strobe |
| cnt_data_i | input | 16 | Count value to load |
| gnt_cpu_o | output | 1 | CPU owns the bus this cycle |
| gnt_dma_o | output | NCH | One-hot channel grant |
| dma_word_o | output | 1 | Granted channel transfers words |
| tc_irq_o | output | NCH | Terminal-count interrupt pulse |
| pin_irq_o | output | NCH | Request pin passed through as an interrupt |

## Verification
Two events can fall in the same cycle: a count load and a grant to the same channel. The bench forces this case. It loads a count of 1, then drives the channel's request and a second load together, so a decrement that would reach zero meets a new value. The expected result is that the loaded value survives, no pulse appears in the next cycle, and the stop comes only after the full new count has been used up. A second collision is an odd-address word start followed at once by a DMA request. This is judged by the CPU still holding the bus in the second cycle and the channel being granted only in the third. A cycle-accurate behavioural model checks both cases, as well as a long random run.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CTRL_W   = 16;
  localparam int B_STOP   = 9;
  localparam int B_TC_IE  = 8;
  localparam int B_HI     = 5;
  localparam int B_TMR    = 4;
  localparam int B_PININT = 3;
  localparam int B_WORD   = 0;

  typedef struct packed {
    logic stop_tc;
    logic tc_ie;
    logic hi_pri;
    logic tmr_src;
    logic pin_int;
    logic word;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_cfg(input logic [CTRL_W-1:0] w);
    chan_cfg_t c;
    c.stop_tc = w[B_STOP];
    c.tc_ie   = w[B_TC_IE];
    c.hi_pri  = w[B_HI];
    c.tmr_src = w[B_TMR];
    c.pin_int = w[B_PININT];
    c.word    = w[B_WORD];
    return c;
  endfunction
endpackage

// File: rtl/dma_chan_unit.sv
module dma_chan_unit
  import dma_arb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              pin_i,
  input  logic              tmr_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              hi_o,
  output logic              word_o,
  output logic              pin_irq_o,
  output logic              irq_o
);
  chan_cfg_t        cfg;
  logic [CNT_W-1:0] cnt_q;
  logic             stopped;
  logic             src;
  logic             ctrl_unused;

  assign cfg         = decode_cfg(ctrl_i);
  assign ctrl_unused = ^{ctrl_i[CTRL_W-1:B_STOP+1], ctrl_i[B_TC_IE-1:B_HI+1],
                         ctrl_i[B_PININT-1:B_WORD+1]};

  assign stopped   = cfg.stop_tc && (cnt_q == '0);
  assign src       = cfg.tmr_src ? tmr_i : (cfg.pin_int ? 1'b0 : pin_i);
  assign req_o     = src && !stopped;
  assign hi_o      = cfg.hi_pri;
  assign word_o    = cfg.word;
  assign pin_irq_o = cfg.pin_int && pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= gnt_i && !load_i && cfg.tc_ie && (cnt_q == CNT_W'(1));
      if (load_i)     cnt_q <= load_val_i;
      else if (gnt_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R6
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && cfg.stop_tc) |-> (cnt_q != '0));
  // R7
  irq_after_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gnt_i));
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] hi_i,
  input  logic           en_i,
  output logic [NCH-1:0] gnt_o,
  output logic           any_o
);
  localparam int PTR_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PTR_W-1:0] rr_q;
  logic [PTR_W-1:0] sel_hi, sel_lo, sel;
  logic             hit_hi, hit_lo;

  // search from the rotation pointer; high-priority group first
  always_comb begin
    int idx;
    hit_hi = 1'b0;
    hit_lo = 1'b0;
    sel_hi = '0;
    sel_lo = '0;
    idx    = 0;
    for (int k = NCH - 1; k >= 0; k--) begin
      idx = int'(rr_q) + k;
      if (idx >= NCH) idx = idx - NCH;
      if (req_i[idx] && hi_i[idx]) begin
        hit_hi = 1'b1;
        sel_hi = PTR_W'(idx);
      end
      if (req_i[idx] && !hi_i[idx]) begin
        hit_lo = 1'b1;
        sel_lo = PTR_W'(idx);
      end
    end
    sel   = hit_hi ? sel_hi : sel_lo;
    any_o = en_i && (hit_hi || hit_lo);
    gnt_o = '0;
    if (any_o) gnt_o[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rr_q <= '0;
    else if (any_o) rr_q <= (int'(sel) == NCH - 1) ? '0 : sel + PTR_W'(1);
  end

  // R12
  pick_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R2
  pick_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> en_i);
endmodule

// File: rtl/bus_gate.sv
module bus_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic cpu_word_i,
  input  logic cpu_addr0_i,
  input  logic cpu_lock_i,
  input  logic nmi_i,
  input  logic dma_any_i,
  output logic dma_en_o,
  output logic gnt_cpu_o
);
  logic split_q;
  logic split_start;

  assign dma_en_o    = !nmi_i && !cpu_lock_i && !split_q;
  assign gnt_cpu_o   = split_q || (cpu_req_i && !dma_any_i);
  assign split_start = gnt_cpu_o && cpu_req_i && cpu_word_i && cpu_addr0_i && !split_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) split_q <= 1'b0;
    else         split_q <= split_start;
  end

  // R5
  split_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gnt_cpu_o && cpu_req_i && cpu_word_i && cpu_addr0_i && !split_q)
      |-> (gnt_cpu_o && !dma_any_i));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_req_i,
  input  logic                  cpu_word_i,
  input  logic                  cpu_addr0_i,
  input  logic                  cpu_lock_i,
  input  logic                  nmi_i,
  input  logic [NCH-1:0]        dma_pin_i,
  input  logic                  tmr2_req_i,
  input  logic [NCH*CTRL_W-1:0] chan_ctrl_i,
  input  logic [NCH-1:0]        cnt_load_i,
  input  logic [CNT_W-1:0]      cnt_data_i,
  output logic                  gnt_cpu_o,
  output logic [NCH-1:0]        gnt_dma_o,
  output logic                  dma_word_o,
  output logic [NCH-1:0]        tc_irq_o,
  output logic [NCH-1:0]        pin_irq_o
);
  logic [NCH-1:0] req, hi, word;
  logic           dma_en, dma_any;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_chan_unit #(.CNT_W(CNT_W)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_i     (chan_ctrl_i[c*CTRL_W +: CTRL_W]),
      .pin_i      (dma_pin_i[c]),
      .tmr_i      (tmr2_req_i),
      .load_i     (cnt_load_i[c]),
      .load_val_i (cnt_data_i),
      .gnt_i      (gnt_dma_o[c]),
      .req_o      (req[c]),
      .hi_o       (hi[c]),
      .word_o     (word[c]),
      .pin_irq_o  (pin_irq_o[c]),
      .irq_o      (tc_irq_o[c])
    );
  end

  dma_pick #(.NCH(NCH)) i_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .hi_i   (hi),
    .en_i   (dma_en),
    .gnt_o  (gnt_dma_o),
    .any_o  (dma_any)
  );

  bus_gate i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_word_i  (cpu_word_i),
    .cpu_addr0_i (cpu_addr0_i),
    .cpu_lock_i  (cpu_lock_i),
    .nmi_i       (nmi_i),
    .dma_any_i   (dma_any),
    .dma_en_o    (dma_en),
    .gnt_cpu_o   (gnt_cpu_o)
  );

  assign dma_word_o = |(gnt_dma_o & word);

  // R3
  lock_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_lock_i |-> (gnt_dma_o == '0));
  // R4
  nmi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |-> (gnt_dma_o == '0));
  // R12
  one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_cpu_o, gnt_dma_o}));
  // R12
  cpu_idle_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && gnt_dma_o == '0) |-> gnt_cpu_o);
endmodule

// File: tb/test_dma_bus_arbiter.sv
module test_dma_bus_arbiter;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_word = 0, cpu_a0 = 0, lock = 0, nmi = 0, tmr = 0;
  logic [NCH-1:0]    pin = '0, load = '0;
  logic [NCH*16-1:0] ctrl = '0;
  logic [15:0]       ldata = '0;
  logic              g_cpu, d_word;
  logic [NCH-1:0]    g_dma, tc_irq, p_irq;

  dma_bus_arbiter #(.NCH(NCH), .CNT_W(16)) i_dma_bus_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_word_i(cpu_word),
    .cpu_addr0_i(cpu_a0), .cpu_lock_i(lock), .nmi_i(nmi), .dma_pin_i(pin),
    .tmr2_req_i(tmr), .chan_ctrl_i(ctrl), .cnt_load_i(load), .cnt_data_i(ldata),
    .gnt_cpu_o(g_cpu), .gnt_dma_o(g_dma), .dma_word_o(d_word),
    .tc_irq_o(tc_irq), .pin_irq_o(p_irq));

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference model state
  int m_cnt[NCH];
  bit m_split, m_irq[NCH];
  int m_rr;
  int e_sel;
  bit e_cpu, e_word;
  bit e_pin[NCH];

  function automatic bit cb(int c, int b);
    return ctrl[c*16 + b];
  endfunction

  function automatic logic [15:0] mk(bit stp, bit ie, bit hi, bit tm, bit pint, bit wd);
    logic [15:0] v = '0;
    v[9] = stp; v[8] = ie; v[5] = hi; v[4] = tm; v[3] = pint; v[0] = wd;
    return v;
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", r, what, act, exp, $time);
    end
  endtask

  function automatic void model_eval();
    bit rq[NCH];
    bit allowed;
    e_sel = -1;
    for (int c = 0; c < NCH; c++) begin
      bit stp, src;
      stp = cb(c, 9) && m_cnt[c] == 0;
      src = cb(c, 4) ? tmr : (cb(c, 3) ? 1'b0 : pin[c]);
      rq[c] = src && !stp;
      e_pin[c] = cb(c, 3) && pin[c];
    end
    allowed = !nmi && !lock && !m_split;
    if (allowed)
      for (int pass = 1; pass >= 0; pass--)
        for (int k = 0; k < NCH; k++) begin
          int i;
          i = (m_rr + k) % NCH;
          if (e_sel < 0 && rq[i] && cb(i, 5) == pass) e_sel = i;
        end
    e_cpu  = m_split || (cpu_req && e_sel < 0);
    e_word = (e_sel >= 0) ? cb(e_sel, 0) : 1'b0;
  endfunction

  function automatic void model_step();
    bit ns;
    ns = e_cpu && cpu_req && cpu_word && cpu_a0 && !m_split;
    for (int c = 0; c < NCH; c++) begin
      m_irq[c] = (e_sel == c) && !load[c] && m_cnt[c] == 1 && cb(c, 8);
      if (load[c])         m_cnt[c] = ldata;
      else if (e_sel == c) m_cnt[c] = (m_cnt[c] + 65535) % 65536;
    end
    if (e_sel >= 0) m_rr = (e_sel + 1) % NCH;
    m_split = ns;
  endfunction

  // called 4 ns after the driving negedge; compares, crosses posedge, returns at next negedge
  task automatic finish_cycle();
    model_eval();
    chk($sformatf("%s/R12", phase), "gnt_cpu", g_cpu, e_cpu);
    for (int c = 0; c < NCH; c++) begin
      chk($sformatf("%s/R2", phase), $sformatf("gnt_dma[%0d]", c), g_dma[c], e_sel == c);
      chk($sformatf("%s/R7", phase), $sformatf("tc_irq[%0d]", c), tc_irq[c], m_irq[c]);
      chk($sformatf("%s/R9", phase), $sformatf("pin_irq[%0d]", c), p_irq[c], e_pin[c]);
    end
    chk($sformatf("%s/R8", phase), "dma_word", d_word, e_word);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic settle();
    #4;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NCH-1:0] g1;
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_irq[c] = 0; end
    m_split = 0; m_rr = 0;
    repeat (3) @(negedge clk);
    settle();
    // R1 reset state
    chk("R1", "gnt_cpu", g_cpu, 0);
    chk("R1", "gnt_dma", g_dma, 0);
    chk("R1", "tc_irq", tc_irq, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R12 CPU alone; R2 DMA over CPU
    phase = "R12"; cpu_req = 1; settle();
    chk("R12", "gnt_cpu alone", g_cpu, 1);
    finish_cycle();
    phase = "R2"; pin = 2'b01; settle();
    chk("R2", "gnt_dma over cpu", g_dma, 1);
    chk("R2", "gnt_cpu loses", g_cpu, 0);
    finish_cycle();

    // R3 lock
    phase = "R3"; lock = 1; settle();
    chk("R3", "gnt_dma under lock", g_dma, 0);
    chk("R3", "gnt_cpu under lock", g_cpu, 1);
    finish_cycle();
    lock = 0;

    // R4 nmi
    phase = "R4"; nmi = 1; settle();
    chk("R4", "gnt_dma under nmi", g_dma, 0);
    chk("R4", "gnt_cpu under nmi", g_cpu, 1);
    finish_cycle();
    nmi = 0;

    // R5 odd word, DMA arrives in second half
    phase = "R5"; pin = 0; cpu_word = 1; cpu_a0 = 1; settle();
    chk("R5", "first half cpu", g_cpu, 1);
    finish_cycle();
    pin = 2'b01; settle();
    chk("R5", "second half cpu", g_cpu, 1);
    chk("R5", "second half dma", g_dma, 0);
    finish_cycle();
    settle();
    chk("R5", "dma after split", g_dma, 1);
    finish_cycle();
    cpu_word = 0; cpu_a0 = 0;

    // R10 round robin
    phase = "R10"; cpu_req = 0; pin = 2'b11; settle();
    g1 = g_dma;
    finish_cycle();
    settle();
    chk("R10", "alternate", g_dma, int'(~g1 & 2'b11));
    finish_cycle();
    settle();
    chk("R10", "back", g_dma, int'(g1));
    finish_cycle();

    // R2 priority bit
    phase = "R2"; ctrl[31:16] = mk(0, 0, 1, 0, 0, 0);
    repeat (2) begin
      settle();
      chk("R2", "hi channel wins", g_dma, 2);
      finish_cycle();
    end
    ctrl = '0; pin = 0;

    // R11/R6/R7 count, stop, interrupt
    phase = "R11"; ctrl[15:0] = mk(1, 1, 0, 0, 0, 0); load = 2'b01; ldata = 16'd2; settle();
    finish_cycle();
    load = 0; pin = 2'b01; phase = "R6";
    settle(); chk("R6", "grant cnt2", g_dma, 1); finish_cycle();
    settle(); chk("R6", "grant cnt1", g_dma, 1); chk("R7", "no early irq", tc_irq, 0); finish_cycle();
    settle(); chk("R6", "stopped at zero", g_dma, 0); chk("R7", "irq pulse", tc_irq, 1); finish_cycle();
    settle(); chk("R7", "irq one cycle", tc_irq, 0); finish_cycle();
    // R11 load colliding with final grant
    phase = "R11"; pin = 0; load = 2'b01; ldata = 16'd1; settle(); finish_cycle();
    pin = 2'b01; ldata = 16'd3; settle();
    chk("R11", "grant during load", g_dma, 1);
    finish_cycle();
    load = 0; settle();
    chk("R11", "no irq on load", tc_irq, 0);
    finish_cycle();
    repeat (2) begin settle(); chk("R11", "loaded count runs", g_dma, 1); finish_cycle(); end
    settle(); chk("R11", "stop after load count", g_dma, 0); finish_cycle();

    // R9 pin as interrupt
    phase = "R9"; ctrl[15:0] = mk(0, 0, 0, 0, 1, 0); cpu_req = 1; settle();
    chk("R9", "pin no request", g_dma, 0);
    chk("R9", "pin irq", p_irq, 1);
    finish_cycle();

    // R8 timer source and word flag
    phase = "R8"; ctrl[15:0] = mk(0, 0, 0, 1, 1, 1); pin = 0; tmr = 1; settle();
    chk("R8", "timer grant", g_dma, 1);
    chk("R8", "word flag", d_word, 1);
    finish_cycle();
    tmr = 0;

    // R6 no-stop wraps: random run covers all
    phase = "RND";
    for (int n = 0; n < 4000; n++) begin
      if (n % 40 == 0)
        for (int c = 0; c < NCH; c++)
          ctrl[c*16 +: 16] = mk($urandom % 2, $urandom % 2, $urandom % 2,
                                ($urandom % 4) == 0, ($urandom % 4) == 0, $urandom % 2);
      cpu_req  = ($urandom % 4) != 0;
      cpu_word = $urandom % 2;
      cpu_a0   = $urandom % 2;
      lock     = ($urandom % 8) == 0;
      nmi      = ($urandom % 10) == 0;
      tmr      = $urandom % 2;
      pin      = NCH'($urandom);
      for (int c = 0; c < NCH; c++) load[c] = ($urandom % 12) == 0;
      ldata    = 16'($urandom % 5);
      settle();
      finish_cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule